// File: doc/BRIEF.md
# Serial Word Deserializer and Boundary Aligner

This block takes a one-bit serial stream, sampled on every edge of a fast bit clock, and assembles it into 10-bit parallel words. The earliest bit of each group lands in bit 0. The word rate is one tenth of the bit rate and is modelled as a one-in-ten strobe inside the same clock domain. A free-running counter sets where each raw word starts, and that start usually differs from the word boundary the transmitter used.

To recover the transmitter's boundary, the block keeps the two most recent raw words as a 20-bit window. At every word strobe it compares a runtime-programmable 10-bit alignment pattern against all ten possible bit offsets in that window. While the search is armed and the pattern appears, the block latches the offset and raises a lock flag. From then on it emits one aligned word per word period from that offset, with a one-cycle valid pulse. A rising edge on the enable input re-arms the search. Reset clears the lock.

Top module: `serial_word_aligner`

## Requirements
- R1: Bits are taken least-significant first. After a lock at offset 0, the arrival sequence 0,0,1,1,1,1,1,0,1,0 (earliest first) comes out as the word 10'h17C.
- R2: Raw word m holds stream bits 10m to 10m+9, counted from the first bit sampled after reset. The word emitted at offset k from raw words m-1 and m holds stream bits 10(m-1)+k up to 10(m-1)+k+9, so it spans both raw words when k is nonzero.
- R3: A search takes place at each word strobe (clock edges 10m+10, m ≥ 0) when the block is unlocked, alignEn is high and there was no alignEn rising edge on that edge. If the pattern matches the window slice at some offset k in 0..9, the lowest such k goes to lockOffset and locked goes to 1.
- R4: While locked, wordValid is high for exactly one cycle in every 10, and wordOut holds the slice at the locked offset.
- R5: The word is visible on the outputs just after the word-strobe edge that follows it. For offset k this is 11-k edges after the edge that samples its last bit. wordValid and wordOut change on the same edge.
- R6: While locked, a pattern match at any other offset leaves lockOffset and the output data unchanged.
- R7: A rising edge of alignEn, meaning alignEn high on an edge where it was low on the previous edge, clears locked, and no word is emitted on that edge. If alignEn falls or stays high, the lock is kept.
- R8: While unlocked with alignEn low, the pattern is never acted on: locked and wordValid stay 0.
- R9: While rstN is low, locked, wordValid, wordOut and lockOffset read 0. The bit counter restarts, so the first bit sampled after release becomes bit 0 of raw word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial data, one bit per clock |
| alignEn | input | 1 | Search enable; a rising edge re-arms the search |
| alignPattern | input | WORD_W | Alignment pattern, bit 0 matched against the earliest bit |
| wordOut | output | WORD_W | Aligned parallel word |
| wordValid | output | 1 | One-cycle strobe per aligned word |
| locked | output | 1 | Boundary found and held |
| lockOffset | output | OFF_W | Latched bit offset, 0..9 |

## Verification
The bench logs the serial bit, the enable and the pattern for every clock edge, indexed by edge number since reset release. After edge e it decides whether a word is due: this happens only when e ≥ 10 and e is a multiple of 10. The word is then the slice beginning at stream bit e-20+offset, with bits before the stream start counted as zero. At the negedge that follows each edge, the bench compares locked, lockOffset, wordValid and wordOut with this model. Because of that, the 11-k edge latency and the enable-edge priority are checked on the exact cycle, and directed checks read the lock state at negedges a known number of bits after each pattern.

// File: rtl/swa_pkg.sv
package swa_pkg;

  // Strobes the control half hands to the datapath each clock.
  typedef struct packed {
    logic takeOffset;  // latch the first matching offset
    logic emitWord;    // load the aligned word register
  } swa_strobe_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HELD = 1'b1
  } swa_state_t;

endpackage

// File: rtl/swa_datapath.sv
module swa_datapath
  import swa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int WIN_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic [WORD_W-1:0] pattern,
  input  swa_strobe_t       strobe,
  output logic              rawStb,
  output logic              anyMatch,
  output logic [OFF_W-1:0]  firstMatch,
  output logic [WORD_W-1:0] wordOut,
  output logic [OFF_W-1:0]  offsetQ
);

  logic [OFF_W-1:0]  bitCnt;
  logic              lastBit;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] prevWord;
  logic [WIN_W-1:0]  window;
  logic [WORD_W-1:0] matchVec;
  logic [OFF_W-1:0]  selOff;
  logic [WORD_W-1:0] aligned;

  assign lastBit   = (bitCnt == OFF_W'(WORD_W - 1));
  // New bits enter at the top so the earliest one ends in bit 0.
  assign nextShift = {serialIn, shiftReg[WORD_W-1:1]};
  assign window    = {curWord, prevWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      curWord  <= '0;
      prevWord <= '0;
      rawStb   <= 1'b0;
    end else begin
      shiftReg <= nextShift;
      bitCnt   <= lastBit ? '0 : bitCnt + 1'b1;
      rawStb   <= lastBit;
      if (lastBit) begin
        curWord  <= nextShift;
        prevWord <= curWord;
      end
    end
  end

  // One comparator per candidate offset.
  for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
    assign matchVec[k] = (window[k +: WORD_W] == pattern);
  end

  // Lowest matching offset wins.
  always_comb begin
    anyMatch   = |matchVec;
    firstMatch = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (matchVec[k]) firstMatch = OFF_W'(k);
    end
  end

  assign selOff = strobe.takeOffset ? firstMatch : offsetQ;

  always_comb begin
    for (int j = 0; j < WORD_W; j++) begin
      aligned[j] = window[int'(selOff) + j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0;
      wordOut <= '0;
    end else begin
      if (strobe.takeOffset) offsetQ <= firstMatch;
      if (strobe.emitWord)   wordOut <= aligned;
    end
  end

endmodule

// File: rtl/swa_control.sv
module swa_control
  import swa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alignEn,
  input  logic        rawStb,
  input  logic        anyMatch,
  output swa_strobe_t strobe,
  output logic        lockedQ,
  output logic        validQ
);

  swa_state_t state;
  logic       alignEnQ;
  logic       rearm;

  assign rearm   = alignEn & ~alignEnQ;
  assign lockedQ = (state == ST_HELD);

  // A re-arm edge takes priority over any word strobe on the same edge.
  always_comb begin
    strobe = '0;
    if (!rearm && rawStb) begin
      if (state == ST_HELD) begin
        strobe.emitWord = 1'b1;
      end else if (alignEn && anyMatch) begin
        strobe.emitWord   = 1'b1;
        strobe.takeOffset = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      alignEnQ <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      alignEnQ <= alignEn;
      validQ   <= strobe.emitWord;
      if (rearm)                  state <= ST_HUNT;
      else if (strobe.takeOffset) state <= ST_HELD;
    end
  end

endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner
  import swa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              alignEn,
  input  logic [WORD_W-1:0] alignPattern,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              locked,
  output logic [OFF_W-1:0]  lockOffset
);

  swa_strobe_t      strobe;
  logic             rawStb;
  logic             anyMatch;
  logic [OFF_W-1:0] firstMatch;

  swa_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .pattern   (alignPattern),
    .strobe    (strobe),
    .rawStb    (rawStb),
    .anyMatch  (anyMatch),
    .firstMatch(firstMatch),
    .wordOut   (wordOut),
    .offsetQ   (lockOffset)
  );

  swa_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .alignEn (alignEn),
    .rawStb  (rawStb),
    .anyMatch(anyMatch),
    .strobe  (strobe),
    .lockedQ (locked),
    .validQ  (wordValid)
  );

endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
  parameter int WORD_W = 10,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int GAP_W = OFF_W + 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             alignEn,
  input logic             wordValid,
  input logic             locked,
  input logic [OFF_W-1:0] lockOffset
);

  logic [GAP_W-1:0] gapCnt;
  logic             haveValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      haveValid <= 1'b0;
    end else if (wordValid) begin
      gapCnt    <= '0;
      haveValid <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R4: two valid strobes never closer than one word period
  a_r4_valid_gap: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && haveValid) |-> (gapCnt >= GAP_W'(WORD_W - 1)));

  // R4: a held lock yields the next word exactly one period later
  a_r4_valid_due: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked) && haveValid && gapCnt == GAP_W'(WORD_W - 1)) |-> wordValid);

  // R6: offset does not move while the lock is held
  a_r6_offset_held: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(lockOffset));

  // R8: no word without a lock
  a_r8_valid_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> locked);

  // R3: a lock is only taken while the search is enabled
  a_r3_lock_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(alignEn));

  // R9: reset leaves no lock and no strobe
  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!locked && !wordValid));

endmodule

bind serial_word_aligner swa_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .alignEn   (alignEn),
  .wordValid (wordValid),
  .locked    (locked),
  .lockOffset(lockOffset)
);

// File: tb/serial_word_aligner_test.sv
`timescale 1ns/1ps
module serial_word_aligner_test;

  localparam int W      = 10;
  localparam int OW     = $clog2(W);
  localparam int MAXB   = 8192;
  localparam int LIMIT  = 150000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          serialIn;
  logic          alignEn;
  logic [W-1:0]  alignPattern;
  logic [W-1:0]  wordOut;
  logic          wordValid;
  logic          locked;
  logic [OW-1:0] lockOffset;

  serial_word_aligner #(.WORD_W(W)) uut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .alignEn(alignEn),
    .alignPattern(alignPattern), .wordOut(wordOut), .wordValid(wordValid),
    .locked(locked), .lockOffset(lockOffset)
  );

  always #2 clk = ~clk;  // 250 MHz

  int compared = 0;
  int mismatched = 0;
  int ec = 0;        // clock edges since reset release
  int doneEdges = 0;
  int cycles = 0;
  bit running = 0;
  bit finished = 0;

  logic         sArr [MAXB];
  logic         aArr [MAXB];
  logic [W-1:0] pArr [MAXB];

  bit           mLocked = 0;
  int           mOff = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, ec);
    end
  endtask

  function automatic logic bitAt(int i);
    return (i < 0) ? 1'b0 : sArr[i];
  endfunction

  function automatic logic [W-1:0] sliceAt(int start);
    logic [W-1:0] v;
    for (int j = 0; j < W; j++) v[j] = bitAt(start + j);
    return v;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finishRun();
    end
  end

  // Reference model evaluated once per edge, compared at the negedge.
  always @(negedge clk) begin
    if (running && ec > doneEdges) begin
      int e;
      bit rise, due, expValid;
      logic [W-1:0] expWord;
      e = ec - 1;
      doneEdges = ec;
      rise = aArr[e] && ((e == 0) ? 1'b1 : !aArr[e-1]);
      due = (e >= W) && (e % W == 0);
      expValid = 0;
      expWord = '0;
      if (rise) begin
        mLocked = 0;
      end else if (due) begin
        if (mLocked) begin
          expValid = 1;
        end else if (aArr[e]) begin
          for (int k = W - 1; k >= 0; k--) begin
            if (sliceAt(e - 2*W + k) == pArr[e]) begin
              mOff = k;
              mLocked = 1;
            end
          end
          expValid = mLocked;
        end
        if (expValid) expWord = sliceAt(e - 2*W + mOff);
      end
      check("R5 wordValid", 32'(wordValid), 32'(expValid));
      check("R7 locked", 32'(locked), 32'(mLocked));
      if (mLocked) check("R3 lockOffset", 32'(lockOffset), 32'(mOff));
      if (expValid) begin
        check("R2 R4 wordOut", 32'(wordOut), 32'(expWord));
        if (expWord == 10'h17C && mOff == 0)
          check("R1 bit order", 32'(wordOut), 32'h17C);
      end
    end
  end

  task automatic sendBit(logic b);
    serialIn = b;
    sArr[ec] = b;
    aArr[ec] = alignEn;
    pArr[ec] = alignPattern;
    @(posedge clk);
    ec++;
    @(negedge clk);
  endtask

  task automatic sendWord(logic [W-1:0] v);
    for (int j = 0; j < W; j++) sendBit(v[j]);
  endtask

  task automatic sendRandom(int n);
    for (int j = 0; j < n; j++) sendBit(1'($urandom()));
  endtask

  // Re-arm and place the pattern so it starts at stream offset off.
  task automatic lockAt(logic [W-1:0] pat, logic pad, int off);
    alignEn = 1'b0;
    alignPattern = pat;
    for (int j = 0; j < 2*W; j++) sendBit(pad);
    alignEn = 1'b1;
    while (ec % W != off) sendBit(pad);
    sendWord(pat);
    sendRandom(25);
    check("R3 locked after pattern", 32'(locked), 32'd1);
    check("R3 offset recovered", 32'(lockOffset), 32'(off));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    serialIn = 1'b0;
    alignEn = 1'b0;
    alignPattern = 10'h17C;
    repeat (4) @(negedge clk);
    check("R9 reset locked", 32'(locked), 32'd0);
    check("R9 reset wordValid", 32'(wordValid), 32'd0);
    check("R9 reset wordOut", 32'(wordOut), 32'd0);
    check("R9 reset lockOffset", 32'(lockOffset), 32'd0);
    rstN = 1'b1;
    running = 1;

    // R8: pattern present, search disabled
    sendWord('0);
    sendWord(10'h17C);
    sendRandom(25);
    check("R8 no lock while disabled", 32'(locked), 32'd0);

    // R1: lock at offset 0, then send the ordering example as data
    lockAt(10'h17C, 1'b0, 0);
    while (ec % W != 0) sendBit(1'($urandom()));
    sendWord(10'h17C);
    sendRandom(2*W + 1);

    // R3 / R2: every offset
    for (int off = 0; off < W; off++) begin
      lockAt(10'h17C, 1'b0, off);
      sendRandom(30);
    end

    // R6: a match at another offset while locked is ignored
    while (ec % W != (9 + 3) % W) sendBit(1'b0);
    sendWord(10'h17C);
    sendRandom(25);
    check("R6 offset kept", 32'(lockOffset), 32'd9);
    check("R6 lock kept", 32'(locked), 32'd1);

    // R7: falling enable keeps the lock
    alignEn = 1'b0;
    sendRandom(30);
    check("R7 lock held after fall", 32'(locked), 32'd1);

    // R3: a different programmed pattern, then random offsets
    lockAt(10'h283, 1'b1, 4);
    sendRandom(200);
    for (int n = 0; n < 6; n++) begin
      lockAt(10'h17C, 1'b0, int'($urandom() % W));
      sendRandom(60);
    end

    // R9: reset in the middle of a lock
    running = 0;
    rstN = 1'b0;
    @(negedge clk);
    check("R9 mid-run locked", 32'(locked), 32'd0);
    check("R9 mid-run wordValid", 32'(wordValid), 32'd0);
    check("R9 mid-run lockOffset", 32'(lockOffset), 32'd0);
    finishRun();
  end

endmodule